// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is an on-chip scratchpad built from 32 independent single-port banks. It serves one group request at a time from 32 lanes. Each lane brings a valid bit, a read/write flag, a byte address and 32 bits of write data. The block works out which bank each lane addresses. When several active lanes land on the same bank, the request is split into successive passes. In each pass every bank serves at most one lane.

While a request is in progress, `req_ready` stays low and no new request is taken. When the last pass has finished, the block raises `resp_done` for one cycle. At that point every lane's read data is valid. It stays unchanged until the next request is accepted.

A mode input picks the bank width for each request. In the 4-byte mode, consecutive 32-bit words fall in consecutive banks. In the 8-byte mode, each bank holds 8-byte entries, and address bit 2 picks the 32-bit half inside an entry. Lanes are always 32 bits wide.

Top module: `spad_serializer`

## Requirements
- R1: With `wide_mode`=0, the bank is byte address bits [6:2] and the row inside the bank is bits [11:7]. A request whose 32 lanes use addresses base+4*i, with base a multiple of 128, touches 32 distinct banks and finishes in one pass.
- R2: With `wide_mode`=1, the bank is address bits [7:3] and the row is {bits [11:8], bit 2}. Lanes at stride 8 finish in one pass. Lanes at stride 4 pair up on 16 banks and need two passes.
- R3: The number of passes P equals the largest number of active lanes that map to any one bank, with P=0 when no lane is active. `resp_done` is high on the (P+1)th rising edge after the accepting edge. Inside one bank, the lowest-numbered lane still pending is served first.
- R4: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the edge after acceptance until `resp_done` rises. Requests presented while it is low have no effect on storage.
- R5: `resp_done` is a single-cycle pulse. `req_ready` is high in the same cycle.
- R6: Lanes that read return what a lane-by-lane execution in ascending lane order would read, so a read sees writes made by lower-numbered lanes of the same request. Read data holds until the next acceptance.
- R7: When several lanes write the same location, the data of the highest-numbered writing lane remains.
- R8: Inactive lanes do not count toward conflicts, never write, and return 0. A request with no active lane raises `resp_done` one edge after acceptance.
- R9: Lanes that write return 0 on `lane_rdata`.
- R10: After reset, `req_ready`=1, `resp_done`=0 and all `lane_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A group request is presented |
| req_ready | output | 1 | Block can accept a request |
| wide_mode | input | 1 | 0: 4-byte banks, 1: 8-byte banks |
| lane_valid | input | LANES | Bit i marks lane i active |
| lane_write | input | LANES | Bit i: 1 write, 0 read |
| lane_addr | input | LANES*ADDR_W | Lane i byte address at [i*ADDR_W +: ADDR_W] |
| lane_wdata | input | LANES*DATA_W | Lane i write data at [i*DATA_W +: DATA_W] |
| resp_done | output | 1 | One-cycle pulse when all passes are finished |
| lane_rdata | output | LANES*DATA_W | Lane i read data at [i*DATA_W +: DATA_W] |

## Verification
The assertions assume that `req_valid` and the lane inputs are driven to known values whenever reset is low. They also assume that only data written since reset is ever read. The stimulus meets both conditions. It fills the whole storage with unit-stride writes before any read. All later addresses fall inside the 4 KB space, and inputs change only on falling edges. Random requests mix both bank widths and often crowd addresses onto one to four banks, so deep conflicts occur. Directed cases cover the 32-way collision, the empty request and requests presented while the block is busy.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic {
    BW4 = 1'b0,
    BW8 = 1'b1
  } bank_width_e;
endpackage

// File: rtl/spad_bank_map.sv
module spad_bank_map #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 12,
  parameter int BANK_W = 5,
  parameter int ROW_W  = ADDR_W - BANK_W - 2
) (
  input  logic                    wide,
  input  logic [LANES*ADDR_W-1:0] addr,
  output logic [LANES*BANK_W-1:0] bank,
  output logic [LANES*ROW_W-1:0]  row
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W-1:0] a;
    assign a = addr[i*ADDR_W +: ADDR_W];
    assign bank[i*BANK_W +: BANK_W] = wide ? a[BANK_W+2:3] : a[BANK_W+1:2];
    assign row[i*ROW_W +: ROW_W]    = wide ? {a[ADDR_W-1:BANK_W+3], a[2]}
                                           : a[ADDR_W-1:BANK_W+2];
  end
endmodule

// File: rtl/spad_pass_sched.sv
module spad_pass_sched #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int BANK_W = 5,
  parameter int LIDX_W = 5
) (
  input  logic [LANES-1:0]        pend,
  input  logic [LANES*BANK_W-1:0] bank,
  output logic [LANES-1:0]        grant,
  output logic [BANKS-1:0]        bank_en,
  output logic [BANKS*LIDX_W-1:0] bank_lane
);
  // lowest pending lane of each bank wins this pass
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < LANES; j++)
        if (j < i && pend[j] && bank[j*BANK_W +: BANK_W] == bank[i*BANK_W +: BANK_W])
          blk = 1'b1;
      grant[i] = pend[i] && !blk;
    end
  end

  always_comb begin
    bank_en   = '0;
    bank_lane = '0;
    for (int b = 0; b < BANKS; b++)
      for (int i = 0; i < LANES; i++)
        if (grant[i] && bank[i*BANK_W +: BANK_W] == BANK_W'(b)) begin
          bank_en[b]                  = 1'b1;
          bank_lane[b*LIDX_W +: LIDX_W] = LIDX_W'(i);
        end
  end
endmodule

// File: rtl/spad_bank.sv
module spad_bank #(
  parameter int ROW_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/spad_serializer.sv
module spad_serializer
  import spad_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    wide_mode,
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES-1:0]        lane_write,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [LANES*DATA_W-1:0] lane_wdata,
  output logic                    resp_done,
  output logic [LANES*DATA_W-1:0] lane_rdata
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W - 2;
  localparam int LIDX_W = $clog2(LANES);

  logic                    busy_q, done_q;
  bank_width_e             mode_q;
  logic [LANES-1:0]        pend_q, wr_q, gnt_q, grant;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*DATA_W-1:0] wd_q;
  logic [DATA_W-1:0]       rdata_q [LANES];
  logic [DATA_W-1:0]       bank_rd [BANKS];
  logic [LANES*BANK_W-1:0] bank_flat;
  logic [LANES*ROW_W-1:0]  row_flat;
  logic [BANKS-1:0]        bank_en;
  logic [BANKS*LIDX_W-1:0] bank_lane;
  logic                    accept;

  assign accept    = req_valid && !busy_q;
  assign req_ready = !busy_q;
  assign resp_done = done_q;

  spad_bank_map #(.LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) map_i (
    .wide(mode_q == BW8), .addr(addr_q), .bank(bank_flat), .row(row_flat)
  );

  spad_pass_sched #(.LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W), .LIDX_W(LIDX_W)) sched_i (
    .pend(busy_q ? pend_q : '0), .bank(bank_flat), .grant(grant),
    .bank_en(bank_en), .bank_lane(bank_lane)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [LIDX_W-1:0] sel;
    assign sel = bank_lane[b*LIDX_W +: LIDX_W];
    spad_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) bank_i (
      .clk(clk), .en(bank_en[b]), .we(bank_en[b] && wr_q[sel]),
      .row(row_flat[sel*ROW_W +: ROW_W]), .wdata(wd_q[sel*DATA_W +: DATA_W]),
      .rdata(bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= BW4;
      pend_q <= '0;
      wr_q   <= '0;
      gnt_q  <= '0;
      for (int i = 0; i < LANES; i++) rdata_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      gnt_q  <= grant;
      for (int i = 0; i < LANES; i++)
        if (gnt_q[i] && !wr_q[i])
          rdata_q[i] <= bank_rd[bank_flat[i*BANK_W +: BANK_W]];
      if (accept) begin
        busy_q <= 1'b1;
        mode_q <= bank_width_e'(wide_mode);
        pend_q <= lane_valid;
        wr_q   <= lane_write;
        for (int i = 0; i < LANES; i++) rdata_q[i] <= '0;
      end else if (busy_q) begin
        pend_q <= pend_q & ~grant;
        if (pend_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= lane_addr;
      wd_q   <= lane_wdata;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_out
    assign lane_rdata[i*DATA_W +: DATA_W] = rdata_q[i];
  end

  // ---------------- assertions ----------------
  logic [LANES-1:0] bank_hits [BANKS];
  logic [LIDX_W+1:0] busy_cyc;

  always_comb
    for (int b = 0; b < BANKS; b++)
      for (int i = 0; i < LANES; i++)
        bank_hits[b][i] = grant[i] && (bank_flat[i*BANK_W +: BANK_W] == BANK_W'(b));

  always_ff @(posedge clk)
    if (rst || !busy_q) busy_cyc <= '0;
    else                busy_cyc <= busy_cyc + 1'b1;

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_done |=> !resp_done);
  // R5
  done_ready_chk: assert property (@(posedge clk) disable iff (rst)
    resp_done |-> req_ready);
  // R3
  pend_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ((pend_q & ~$past(pend_q)) == '0));
  // R3
  pass_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy_cyc <= (LIDX_W+2)'(LANES + 1));
  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !req_valid) |=> $stable(lane_rdata));

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    // R3
    one_lane_per_bank_chk: assert property (@(posedge clk) disable iff (rst)
      busy_q |-> $onehot0(bank_hits[b]));
  end
endmodule

// File: tb/spad_serializer_tb.sv
`timescale 1ns/1ps
module spad_serializer_tb_top;
  localparam int LANES  = 32;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int WORDS  = 1 << (ADDR_W - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready, wide_mode = 1'b0, resp_done;
  logic [LANES-1:0] lane_valid = '0, lane_write = '0;
  logic [LANES*ADDR_W-1:0] lane_addr = '0;
  logic [LANES*DATA_W-1:0] lane_wdata = '0, lane_rdata;

  always #5 clk = ~clk;

  spad_serializer dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .wide_mode(wide_mode), .lane_valid(lane_valid), .lane_write(lane_write),
    .lane_addr(lane_addr), .lane_wdata(lane_wdata), .resp_done(resp_done),
    .lane_rdata(lane_rdata)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [31:0] model [WORDS];
  bit m_mode;
  logic [LANES-1:0] m_v, m_w;
  logic [ADDR_W-1:0] m_a [LANES];
  logic [31:0] m_d [LANES];
  logic [31:0] m_exp [LANES];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bank_of(input logic [ADDR_W-1:0] a, input bit wide);
    return wide ? int'(a[7:3]) : int'(a[6:2]);
  endfunction

  function automatic int loc_of(input logic [ADDR_W-1:0] a, input bit wide);
    int row;
    row = wide ? int'({a[11:8], a[2]}) : int'(a[11:7]);
    return bank_of(a, wide) * 32 + row;
  endfunction

  function automatic int passes();
    int cnt [32];
    int mx = 0;
    for (int b = 0; b < 32; b++) cnt[b] = 0;
    for (int i = 0; i < LANES; i++)
      if (m_v[i]) cnt[bank_of(m_a[i], m_mode)]++;
    for (int b = 0; b < 32; b++) if (cnt[b] > mx) mx = cnt[b];
    return mx;
  endfunction

  // ascending lane order model; updates storage model
  function automatic void predict();
    for (int i = 0; i < LANES; i++) begin
      m_exp[i] = 32'h0;
      if (m_v[i]) begin
        if (m_w[i]) model[loc_of(m_a[i], m_mode)] = m_d[i];
        else        m_exp[i] = model[loc_of(m_a[i], m_mode)];
      end
    end
  endfunction

  task automatic do_req(input bit inject, input bit hold, input string tag);
    int p, n;
    logic [LANES*DATA_W-1:0] snap;
    p = passes();
    predict();
    @(negedge clk);
    chk(req_ready === 1'b1, "R4", 32'(req_ready), 32'd1);
    wide_mode  = m_mode;
    lane_valid = m_v;
    lane_write = m_w;
    for (int i = 0; i < LANES; i++) begin
      lane_addr[i*ADDR_W +: ADDR_W]  = m_a[i];
      lane_wdata[i*DATA_W +: DATA_W] = m_d[i];
    end
    req_valid = 1'b1;
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        req_valid = inject;
        if (inject) begin
          lane_valid = '1;
          lane_write = '1;
          lane_wdata = {LANES{32'hDEAD_BEEF}};
        end
      end
      if (resp_done === 1'b1 || n > 40) begin
        req_valid = 1'b0;
        break;
      end
      chk(req_ready === 1'b0, "R4", 32'(req_ready), 32'd0);
    end
    chk(n == p + 2, tag, 32'(n - 1), 32'(p + 1));
    chk(req_ready === 1'b1, "R5", 32'(req_ready), 32'd1);
    for (int i = 0; i < LANES; i++)
      chk(lane_rdata[i*DATA_W +: DATA_W] === m_exp[i],
          !m_v[i] ? "R8" : (m_w[i] ? "R9" : "R6"), lane_rdata[i*DATA_W +: DATA_W], m_exp[i]);
    snap = lane_rdata;
    @(negedge clk);
    chk(resp_done === 1'b0, "R5", 32'(resp_done), 32'd0);
    if (hold) begin
      repeat (3) @(negedge clk);
      chk(lane_rdata === snap, "R6", lane_rdata[31:0], snap[31:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(req_ready === 1'b1, "R10", 32'(req_ready), 32'd1);
    chk(resp_done === 1'b0, "R10", 32'(resp_done), 32'd0);
    chk(lane_rdata === '0, "R10", lane_rdata[31:0], 32'd0);

    // R1 fill storage with unit-stride writes, one pass each
    for (int r = 0; r < 32; r++) begin
      m_mode = 1'b0; m_v = '1; m_w = '1;
      for (int i = 0; i < LANES; i++) begin
        m_a[i] = ADDR_W'(r*128 + i*4);
        m_d[i] = $urandom;
      end
      do_req(1'b0, 1'b0, "R1");
    end
    // R1 unit-stride read, one pass
    m_mode = 1'b0; m_v = '1; m_w = '0;
    for (int i = 0; i < LANES; i++) m_a[i] = ADDR_W'(384 + i*4);
    do_req(1'b0, 1'b1, "R1");
    // R2 stride 8 in wide mode, one pass
    m_mode = 1'b1;
    for (int i = 0; i < LANES; i++) m_a[i] = ADDR_W'(1024 + i*8);
    do_req(1'b0, 1'b0, "R2");
    // R2 stride 4 in wide mode, two passes
    for (int i = 0; i < LANES; i++) m_a[i] = ADDR_W'(2048 + i*4);
    do_req(1'b0, 1'b0, "R2");
    // R7 all lanes write one word: 32 passes, last lane wins
    m_mode = 1'b0; m_w = '1;
    for (int i = 0; i < LANES; i++) begin m_a[i] = 12'h104; m_d[i] = 32'hA000_0000 + 32'(i); end
    do_req(1'b0, 1'b0, "R3");
    m_w = '0; m_v = 32'h1;
    do_req(1'b0, 1'b0, "R7");
    chk(lane_rdata[31:0] === 32'hA000_001F, "R7", lane_rdata[31:0], 32'hA000_001F);
    // R8 empty request, one edge
    m_v = '0;
    do_req(1'b0, 1'b0, "R8");
    // R8 inactive lane carrying a write leaves storage alone
    m_v = 32'h1; m_w = 32'h3;
    m_a[0] = 12'h200; m_d[0] = 32'h1111_2222;
    m_a[1] = 12'h204; m_d[1] = 32'h3333_4444;
    do_req(1'b0, 1'b0, "R8");
    m_v = 32'h2; m_w = '0;
    do_req(1'b0, 1'b0, "R8");
    // R4 request presented while busy is ignored (checked by readback below)
    m_mode = 1'b0; m_v = '1; m_w = '0;
    for (int i = 0; i < LANES; i++) m_a[i] = 12'h300;
    do_req(1'b1, 1'b1, "R4");

    // random mix with crowded banks
    for (int t = 0; t < 300; t++) begin
      int k;
      m_mode = 1'($urandom);
      k = ($urandom % 4 == 0) ? 1 : (1 << ($urandom % 6));
      for (int i = 0; i < LANES; i++) begin
        m_v[i] = ($urandom % 4) != 0;
        m_w[i] = ($urandom % 3) == 0;
        m_a[i] = ADDR_W'($urandom);
        if ($urandom % 2 == 0) begin
          if (m_mode) m_a[i][7:3] = 5'($urandom % k);
          else        m_a[i][6:2] = 5'($urandom % k);
        end
        m_d[i] = $urandom;
      end
      do_req(1'b0, (t % 50) == 0, "R3");
    end

    // full readback, also proves ignored writes left no trace (R4)
    for (int r = 0; r < 32; r++) begin
      m_mode = 1'b0; m_v = '1; m_w = '0;
      for (int i = 0; i < LANES; i++) m_a[i] = ADDR_W'(r*128 + i*4);
      do_req(1'b0, 1'b0, "R4");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule